// File: doc/BRIEF.md
# Host-Port Firmware Load Engine

This block turns a stream of 24-bit words, taken one at a time from a host data port with a valid/ready handshake, into write strobes for a processor's program (P), X and Y memories. It also issues a start-execution pulse with a target address. It works in two phases.

After reset it is in the bootstrap phase. The first word is a length, the second is a load address, and then exactly that many words go into P memory at consecutive addresses. When the last of those words has been written, the block pulses start toward the load address. The typical image is 256 words at P address 0x0100.

It then moves to the chunk phase, where a small resident handler interprets commands. Each chunk begins with a command word and an address. Memory commands also carry a size word and then data. A jump command ends loading.

Top module: `fw_load_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `cmd_error` is 0, and all write strobes and `start_exec` are 0.
- R2: In the bootstrap phase, word 0 is a length N, word 1 is an address A, and the next N words are written to P memory at A, A+1, … A+N−1. Each strobe appears in the cycle after its word is accepted.
- R3: In the bootstrap phase, `start_exec` pulses for one cycle with `start_addr` = A, in the same cycle as the write of the final word. When N = 0, it pulses in the cycle after the address word is accepted, with no write.
- R4: In the chunk phase, a full command word of value 0, 1 or 2 writes the chunk's data to P, X or Y memory respectively. The chunk is command, address, size S, then S data words, written at the address and the addresses after it.
- R5: Command value 3 writes interleaved pairs, with S counting pairs. The first word of a pair goes to X and the second to Y at the same address, and the address then advances by one.
- R6: A chunk with S = 0 writes nothing, and the next accepted word is taken as a command.
- R7: Command value 4 takes exactly one further word, the target. It pulses `start_exec` with that target, and `in_ready` then stays 0 until reset.
- R8: A command word whose value is above 4 writes nothing and sets `cmd_error`, which stays set until reset. The next word is taken as a command.
- R9: While `in_valid` is 0, no word is consumed, no strobe or start pulse occurs, and the load resumes unchanged when words return.
- R10: At most one of `p_we`, `x_we` and `y_we` is high in any cycle. Addresses wrap modulo 2^17 (program space 0x00000–0x1FFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 24 | Word from the host port |
| in_valid | input | 1 | `in_word` holds a word |
| in_ready | output | 1 | Engine can accept a word |
| p_we | output | 1 | Program memory write strobe |
| x_we | output | 1 | X memory write strobe |
| y_we | output | 1 | Y memory write strobe |
| mem_addr | output | 17 | Write address shared by all memories |
| mem_data | output | 24 | Write data shared by all memories |
| start_exec | output | 1 | One-cycle start-execution pulse |
| start_addr | output | 17 | Execution target while `start_exec` is high |
| cmd_error | output | 1 | Sticky flag for an unknown command |

## Verification
The final bootstrap write and the hand-off of execution land in the same cycle. The P strobe for the last image word and the start pulse toward the load address are both high together. The bench provokes this with bootstrap lengths of 256, 2 and 1, and with 0, where the pulse must come alone. It tags every expected start pulse with whether a P write must accompany it and compares `p_we` in the observed cycle.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

    typedef enum logic [3:0] {
        S_BLEN,
        S_BADDR,
        S_BDATA,
        S_CMD,
        S_CADDR,
        S_CSIZE,
        S_CDATA,
        S_DONE
    } ld_state_e;

    typedef enum logic [2:0] {
        K_P   = 3'd0,
        K_X   = 3'd1,
        K_Y   = 3'd2,
        K_XY  = 3'd3,
        K_JMP = 3'd4
    } ld_kind_e;

endpackage

// File: rtl/fwl_cmd_decode.sv
module fwl_cmd_decode
    import fwl_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic [WORD_W-1:0] cmd_word,
    output ld_kind_e          cmd_kind,
    output logic              cmd_legal
);

    localparam logic [WORD_W-1:0] MAX_CODE = WORD_W'(4);

    always_comb begin
        cmd_legal = (cmd_word <= MAX_CODE);
        cmd_kind  = K_P;
        if (cmd_legal) begin
            unique case (cmd_word[2:0])
                3'd0:    cmd_kind = K_P;
                3'd1:    cmd_kind = K_X;
                3'd2:    cmd_kind = K_Y;
                3'd3:    cmd_kind = K_XY;
                default: cmd_kind = K_JMP;
            endcase
        end
    end

endmodule

// File: rtl/fwl_core.sv
module fwl_core
    import fwl_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    input  ld_kind_e          cmd_kind,
    input  logic              cmd_legal,
    output logic              in_ready,
    output logic              p_we,
    output logic              x_we,
    output logic              y_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              start_exec,
    output logic [ADDR_W-1:0] start_addr,
    output logic              cmd_error
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [WORD_W-1:0] CNT_ONE  = WORD_W'(1);

    typedef struct packed {
        ld_state_e         st;
        ld_kind_e          kind;
        logic              half;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] entry;
        logic [WORD_W-1:0] remain;
        logic              p_we;
        logic              x_we;
        logic              y_we;
        logic [ADDR_W-1:0] waddr;
        logic [WORD_W-1:0] wdata;
        logic              start;
        logic [ADDR_W-1:0] saddr;
        logic              err;
    } core_t;

    core_t ld_d, ld_q;
    logic  take;
    logic  step;

    assign take = in_valid && (ld_q.st != S_DONE);

    always_comb begin
        ld_d       = ld_q;
        ld_d.p_we  = 1'b0;
        ld_d.x_we  = 1'b0;
        ld_d.y_we  = 1'b0;
        ld_d.start = 1'b0;
        step       = 1'b0;
        if (take) begin
            unique case (ld_q.st)
                S_BLEN: begin
                    ld_d.remain = in_word;
                    ld_d.st     = S_BADDR;
                end
                S_BADDR: begin
                    ld_d.addr  = in_word[ADDR_W-1:0];
                    ld_d.entry = in_word[ADDR_W-1:0];
                    if (ld_q.remain == '0) begin
                        ld_d.start = 1'b1;
                        ld_d.saddr = in_word[ADDR_W-1:0];
                        ld_d.st    = S_CMD;
                    end else begin
                        ld_d.st = S_BDATA;
                    end
                end
                S_BDATA: begin
                    ld_d.p_we   = 1'b1;
                    ld_d.waddr  = ld_q.addr;
                    ld_d.wdata  = in_word;
                    ld_d.addr   = ld_q.addr + ADDR_ONE;
                    ld_d.remain = ld_q.remain - CNT_ONE;
                    if (ld_q.remain == CNT_ONE) begin
                        ld_d.start = 1'b1;
                        ld_d.saddr = ld_q.entry;
                        ld_d.st    = S_CMD;
                    end
                end
                S_CMD: begin
                    if (cmd_legal) begin
                        ld_d.kind = cmd_kind;
                        ld_d.st   = S_CADDR;
                    end else begin
                        ld_d.err = 1'b1;
                    end
                end
                S_CADDR: begin
                    ld_d.addr = in_word[ADDR_W-1:0];
                    if (ld_q.kind == K_JMP) begin
                        ld_d.start = 1'b1;
                        ld_d.saddr = in_word[ADDR_W-1:0];
                        ld_d.st    = S_DONE;
                    end else begin
                        ld_d.st = S_CSIZE;
                    end
                end
                S_CSIZE: begin
                    ld_d.remain = in_word;
                    ld_d.half   = 1'b0;
                    ld_d.st     = (in_word == '0) ? S_CMD : S_CDATA;
                end
                S_CDATA: begin
                    ld_d.waddr = ld_q.addr;
                    ld_d.wdata = in_word;
                    unique case (ld_q.kind)
                        K_P: begin
                            ld_d.p_we = 1'b1;
                            step      = 1'b1;
                        end
                        K_X: begin
                            ld_d.x_we = 1'b1;
                            step      = 1'b1;
                        end
                        K_Y: begin
                            ld_d.y_we = 1'b1;
                            step      = 1'b1;
                        end
                        K_XY: begin
                            if (!ld_q.half) begin
                                ld_d.x_we = 1'b1;
                                ld_d.half = 1'b1;
                            end else begin
                                ld_d.y_we = 1'b1;
                                ld_d.half = 1'b0;
                                step      = 1'b1;
                            end
                        end
                        default: step = 1'b1;
                    endcase
                    if (step) begin
                        ld_d.addr   = ld_q.addr + ADDR_ONE;
                        ld_d.remain = ld_q.remain - CNT_ONE;
                        if (ld_q.remain == CNT_ONE) begin
                            ld_d.st = S_CMD;
                        end
                    end
                end
                default: ld_d.st = ld_q.st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q <= '{st: S_BLEN, kind: K_P, default: '0};
        end else begin
            ld_q <= ld_d;
        end
    end

    assign in_ready   = (ld_q.st != S_DONE);
    assign p_we       = ld_q.p_we;
    assign x_we       = ld_q.x_we;
    assign y_we       = ld_q.y_we;
    assign mem_addr   = ld_q.waddr;
    assign mem_data   = ld_q.wdata;
    assign start_exec = ld_q.start;
    assign start_addr = ld_q.saddr;
    assign cmd_error  = ld_q.err;

endmodule

// File: rtl/fw_load_engine.sv
module fw_load_engine
    import fwl_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              p_we,
    output logic              x_we,
    output logic              y_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              start_exec,
    output logic [ADDR_W-1:0] start_addr,
    output logic              cmd_error
);

    ld_kind_e dec_kind;
    logic     dec_legal;

    fwl_cmd_decode #(.WORD_W(WORD_W)) u_dec (
        .cmd_word  (in_word),
        .cmd_kind  (dec_kind),
        .cmd_legal (dec_legal)
    );

    fwl_core #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_word    (in_word),
        .in_valid   (in_valid),
        .cmd_kind   (dec_kind),
        .cmd_legal  (dec_legal),
        .in_ready   (in_ready),
        .p_we       (p_we),
        .x_we       (x_we),
        .y_we       (y_we),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .start_exec (start_exec),
        .start_addr (start_addr),
        .cmd_error  (cmd_error)
    );

endmodule

// File: rtl/fwl_load_chk.sv
module fwl_load_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic p_we,
    input logic x_we,
    input logic y_we,
    input logic start_exec,
    input logic cmd_error
);

    // R9
    strobe_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_we || x_we || y_we || start_exec) |-> $past(in_valid && in_ready));

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({p_we, x_we, y_we}));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |=> cmd_error);

    // R7
    ready_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> !in_ready);

    // R3
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_exec |=> !start_exec);

endmodule

bind fw_load_engine fwl_load_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .p_we       (p_we),
    .x_we       (x_we),
    .y_we       (y_we),
    .start_exec (start_exec),
    .cmd_error  (cmd_error)
);

// File: tb/fw_load_engine_tb.sv
module fw_load_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        p_we, x_we, y_we;
    logic [16:0] mem_addr;
    logic [23:0] mem_data;
    logic        start_exec;
    logic [16:0] start_addr;
    logic        cmd_error;

    always #5 clk = ~clk;

    fw_load_engine u_dut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .p_we(p_we), .x_we(x_we), .y_we(y_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .start_exec(start_exec),
        .start_addr(start_addr), .cmd_error(cmd_error)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // expected event queue: kind 0=P 1=X 2=Y 3=start
    int          q_kind [0:4095];
    logic [16:0] q_addr [0:4095];
    logic [23:0] q_data [0:4095];
    bit          q_co   [0:4095];
    string       q_req  [0:4095];
    int          wr_i = 0;
    int          rd_i = 0;

    task automatic push(int k, logic [16:0] a, logic [23:0] d, bit co, string r);
        q_kind[wr_i] = k; q_addr[wr_i] = a; q_data[wr_i] = d;
        q_co[wr_i] = co; q_req[wr_i] = r;
        wr_i++;
    endtask

    task automatic check(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // event monitor, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            int wk;
            wk = p_we ? 0 : x_we ? 1 : y_we ? 2 : -1;
            if (wk >= 0) begin
                if (rd_i >= wr_i) begin
                    check(0, "R9", "unexpected write", 32'(mem_addr), 32'hFFFFFFFF);
                end else begin
                    check(q_kind[rd_i] == wk, q_req[rd_i], "write memory", 32'(wk), 32'(q_kind[rd_i]));
                    check(mem_addr == q_addr[rd_i], q_req[rd_i], "write address", 32'(mem_addr), 32'(q_addr[rd_i]));
                    check(mem_data == q_data[rd_i], q_req[rd_i], "write data", 32'(mem_data), 32'(q_data[rd_i]));
                    rd_i++;
                end
            end
            if (start_exec) begin
                if (rd_i >= wr_i || q_kind[rd_i] != 3) begin
                    check(0, "R7", "unexpected start", 32'(start_addr), 32'hFFFFFFFF);
                end else begin
                    check(start_addr == q_addr[rd_i], q_req[rd_i], "start address", 32'(start_addr), 32'(q_addr[rd_i]));
                    check(p_we == q_co[rd_i], "R3", "write with start", 32'(p_we), 32'(q_co[rd_i]));
                    rd_i++;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            check(0, "R9", "watchdog", 32'(cycles), 32'd150000);
            finish_run();
        end
    end

    task automatic send(logic [23:0] w);
        in_word  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        in_word  = 24'h0BAD00;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "ready after reset", 32'(in_ready), 1);
        check(cmd_error == 1'b0, "R1", "error after reset", 32'(cmd_error), 0);
        check({p_we, x_we, y_we, start_exec} == 4'b0, "R1", "strobes after reset",
              32'({p_we, x_we, y_we, start_exec}), 0);
    endtask

    function automatic logic [23:0] bdat(int i);
        return 24'hB00000 + 24'(i * 37);
    endfunction

    task automatic boot(int n, logic [16:0] a);
        send(24'(n));
        if (n == 0) push(3, a, '0, 0, "R3");
        send(24'(a));
        for (int i = 0; i < n; i++) begin
            push(0, a + 17'(i), bdat(i), 0, "R2");
            if (i == n - 1) push(3, a, '0, 1, "R3");
            send(bdat(i));
        end
    endtask

    task automatic chunk(int cmd, logic [16:0] a, int sz);
        string r;
        r = (cmd == 3) ? "R5" : (sz == 0) ? "R6" : "R4";
        send(24'(cmd));
        send(24'(a));
        send(24'(sz));
        for (int i = 0; i < sz; i++) begin
            if (cmd == 3) begin
                logic [23:0] dx, dy;
                dx = 24'h300000 + 24'(i * 2);
                dy = 24'h300001 + 24'(i * 2);
                push(1, a + 17'(i), dx, 0, r);
                send(dx);
                push(2, a + 17'(i), dy, 0, r);
                send(dy);
            end else begin
                logic [23:0] d;
                d = 24'(cmd << 20) + 24'(a) + 24'(i * 5);
                push(cmd, a + 17'(i), d, 0, r);
                send(d);
            end
        end
    endtask

    task automatic jump(logic [16:0] a);
        send(24'd4);
        push(3, a, '0, 0, "R7");
        send(24'(a));
    endtask

    task automatic drained(string r);
        idle(3);
        check(rd_i == wr_i, r, "pending expected events", 32'(rd_i), 32'(wr_i));
    endtask

    initial begin
        // run A: full-size image, all chunk kinds, errors, stalls, jump
        do_reset();
        boot(256, 17'h00100);
        drained("R3");
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 4; s++) begin
                chunk(c, 17'(c * 17'h800 + s * 17'h40), s);
            end
        end
        drained("R4");
        check(cmd_error == 1'b0, "R8", "error before bad code", 32'(cmd_error), 0);
        send(24'd5);
        idle(1);
        check(cmd_error == 1'b1, "R8", "error after code 5", 32'(cmd_error), 1);
        send(24'hFFFFFF);
        chunk(1, 17'h01234, 2);
        drained("R8");
        check(cmd_error == 1'b1, "R8", "error stays set", 32'(cmd_error), 1);
        // stall in the middle of an interleaved chunk
        send(24'd3);
        send(24'h00500);
        idle(4);
        send(24'd2);
        push(1, 17'h00500, 24'h777001, 0, "R9");
        send(24'h777001);
        idle(5);
        push(2, 17'h00500, 24'h777002, 0, "R9");
        send(24'h777002);
        idle(2);
        push(1, 17'h00501, 24'h777003, 0, "R9");
        send(24'h777003);
        push(2, 17'h00501, 24'h777004, 0, "R9");
        send(24'h777004);
        drained("R9");
        // wrap at top of program space
        chunk(0, 17'h1FFFE, 3);
        drained("R10");
        jump(17'h1ABCD);
        idle(2);
        check(in_ready == 1'b0, "R7", "ready after jump", 32'(in_ready), 0);
        in_valid = 1'b1;
        in_word = 24'd0;
        repeat (4) @(negedge clk);
        check(in_ready == 1'b0, "R7", "ready stays low", 32'(in_ready), 0);
        drained("R7");

        // run B: empty bootstrap
        do_reset();
        boot(0, 17'h00040);
        drained("R3");
        chunk(2, 17'h00010, 1);
        jump(17'h00040);
        drained("R7");

        // run C: two-word bootstrap across the address wrap
        do_reset();
        boot(2, 17'h1FFFF);
        drained("R10");

        // run D: one-word bootstrap
        do_reset();
        boot(1, 17'h00100);
        chunk(3, 17'h00020, 1);
        jump(17'h00100);
        drained("R3");

        finish_run();
    end

endmodule